// File: doc/BRIEF.md
# Three-Colour AFE Output Deinterleaver

This block sits behind a triple-channel CCD analog front end whose 12-bit converter delivers each sample as two transfers on an 8-bit bus: the upper part after the converter clock falls and the lower part after it rises. The block runs on a fast system clock and oversamples the converter clock and the colour-sync line. It rebuilds each sample from its two halves in either of two packing formats. It follows the red, green, blue rotation of the multiplexer and skips the samples that the conversion pipeline produces before real data reaches the bus. It then emits each completed pixel as one 36-bit word.

The colour of the data on the bus lags the colour being sampled by the pipeline depth. A short history of colour tags is kept for this reason, so that every rebuilt sample is labelled with the colour it was taken from. The pixel stream leaves on a valid/ready interface. The converter cannot be paused, so back-pressure is absorbed by one output register. An unaccepted pixel is held stable until accepted, unless a newer pixel completes first, which replaces it.

Each half period of the converter clock must last at least four system clocks. The packing mode and the latency select must be held constant while the sync line is low.

Top module: `afe_rgb_deint`

## Requirements
- R1: After a synchronous active-high reset, `pix_valid_o` is low and `pix_data_o` is all zeros.
- R2: With `pack_mode_i` = 0 (6+6 packing), sample bits [11:6] come from bus bits [7:2] of the transfer after the falling edge, and sample bits [5:0] come from bus bits [7:2] of the transfer after the rising edge. Bus bits [1:0] are ignored.
- R3: With `pack_mode_i` = 1 (8+4 packing), sample bits [11:4] come from bus bits [7:0] of the falling-edge transfer, and sample bits [3:0] come from bus bits [7:4] of the rising-edge transfer. Bus bits [3:0] of that second transfer are ignored.
- R4: Kept samples are labelled red, green, blue in rotation, starting from red at the first kept sample after the sync line is released. `pix_data_o` is {red[35:24], green[23:12], blue[11:0]} of three consecutive kept samples.
- R5: While `synch_i` is high, the colour pointer returns to red, bus contents are ignored, no pixel is produced, and any partly assembled triplet is discarded.
- R6: With `lat_short_i` = 0, the first 8 conversions after `synch_i` falls are discarded, and sample 8 (counting from 0) is the first red one.
- R7: With `lat_short_i` = 1, the first 6 conversions after `synch_i` falls are discarded, and sample 6 is the first red one.
- R8: While `pix_valid_o` is high and `pix_ready_i` is low, `pix_valid_o` stays high and `pix_data_o` stays unchanged until a new triplet completes. A pixel is transferred on a clock where both are high.
- R9: A triplet that completes while an earlier pixel is still unaccepted replaces it in `pix_data_o`. Only the newer pixel is then delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the converter clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_clk_i | input | 1 | Converter clock, oversampled |
| synch_i | input | 1 | High: colour rotation held at red, bus not driven |
| pack_mode_i | input | 1 | 0 = 6+6 packing, 1 = 8+4 packing |
| lat_short_i | input | 1 | 0 = 8-conversion pipeline, 1 = 6-conversion pipeline |
| bus_i | input | 8 | Time-multiplexed sample halves |
| pix_ready_i | input | 1 | Consumer accepts the pixel |
| pix_valid_o | output | 1 | Pixel word available |
| pix_data_o | output | 36 | {red, green, blue} pixel |

## Verification
The bench targets the edge of the latency window. A burst that is only two samples longer than the discard count must give no pixel, and a design that counted one conversion too few would shift every colour by one lane. Bus noise is put in the ignored low bits, so a wrong slice in either packing shows up in the data. A sync pulse is inserted in the middle of a triplet, which catches a design that keeps the stale red and green. A stalled consumer catches a register that drops, repeats or fails to replace a held pixel.

// File: rtl/afe_deint_pkg.sv
package afe_deint_pkg;

  typedef enum logic [1:0] {
    COL_RED = 2'd0,
    COL_GRN = 2'd1,
    COL_BLU = 2'd2
  } colour_e;

  function automatic colour_e next_colour(input colour_e c);
    case (c)
      COL_RED: next_colour = COL_GRN;
      COL_GRN: next_colour = COL_BLU;
      default: next_colour = COL_RED;
    endcase
  endfunction

endpackage

// File: rtl/afe_edge_sync.sv
// Oversamples the converter clock and the sync line; emits one-cycle
// strokes one system clock after each detected converter-clock edge.
module afe_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic adc_clk_i,
  input  logic synch_i,
  output logic fall_o,
  output logic rise_o,
  output logic synch_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] ck_sh;
  logic [TOP:0] sy_sh;
  logic         ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sh   <= '0;
      sy_sh   <= '1;
      ck_prev <= 1'b0;
      fall_o  <= 1'b0;
      rise_o  <= 1'b0;
      synch_o <= 1'b1;
    end else begin
      ck_sh   <= {ck_sh[TOP-1:0], adc_clk_i};
      sy_sh   <= {sy_sh[TOP-1:0], synch_i};
      ck_prev <= ck_sh[TOP];
      fall_o  <= ck_prev & ~ck_sh[TOP];
      rise_o  <= ~ck_prev & ck_sh[TOP];
      synch_o <= sy_sh[TOP];
    end
  end
endmodule

// File: rtl/afe_colour_track.sv
// Colour pointer, conversion counter and tag history that maps the
// colour being sampled to the colour of the data now on the bus.
module afe_colour_track
  import afe_deint_pkg::*;
#(
  parameter int LAT_LONG  = 8,
  parameter int LAT_SHORT = 6
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    fall_i,
  input  logic    synch_i,
  input  logic    lat_short_i,
  output colour_e ptr_o,
  output colour_e tag_o,
  output logic    keep_o
);
  localparam int CNT_W = $clog2(LAT_LONG + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LAT_LONG);
  localparam logic [CNT_W-1:0] CNT_SH  = CNT_W'(LAT_SHORT);

  logic [LAT_LONG-1:0][1:0] hist;
  logic [CNT_W-1:0]         conv_cnt;
  logic [CNT_W-1:0]         lat_now;
  logic [1:0]               tap;

  assign lat_now = lat_short_i ? CNT_SH : CNT_MAX;
  assign tap     = lat_short_i ? hist[LAT_SHORT-1] : hist[LAT_LONG-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      conv_cnt <= '0;
      ptr_o    <= COL_RED;
      tag_o    <= COL_RED;
      keep_o   <= 1'b0;
    end else if (synch_i) begin
      conv_cnt <= '0;
      ptr_o    <= COL_RED;
      keep_o   <= 1'b0;
    end else if (fall_i) begin
      hist   <= {hist[LAT_LONG-2:0], 2'(ptr_o)};
      ptr_o  <= next_colour(ptr_o);
      tag_o  <= colour_e'(tap);
      keep_o <= (conv_cnt >= lat_now);
      if (conv_cnt != CNT_MAX) conv_cnt <= conv_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/afe_word_unpack.sv
// Joins the two bus transfers of one conversion into a full sample.
module afe_word_unpack #(
  parameter int BUS_W  = 8,
  parameter int SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic              pack_mode_i,
  input  logic [BUS_W-1:0]  bus_i,
  output logic [SAMP_W-1:0] samp_o,
  output logic              samp_vld_o
);
  localparam int HALF   = SAMP_W / 2;
  localparam int NARROW = SAMP_W - BUS_W;

  logic [BUS_W-1:0]  hi_q;
  logic [SAMP_W-1:0] joined;

  always_comb begin
    if (pack_mode_i) joined = {hi_q, bus_i[BUS_W-1 -: NARROW]};
    else             joined = {hi_q[BUS_W-1 -: HALF], bus_i[BUS_W-1 -: HALF]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      samp_o     <= '0;
      samp_vld_o <= 1'b0;
    end else begin
      samp_vld_o <= cap_lo_i;
      if (cap_hi_i) hi_q <= bus_i;
      if (cap_lo_i) samp_o <= joined;
    end
  end
endmodule

// File: rtl/afe_triplet_pack.sv
// Collects red and green, closes the pixel on blue, holds it for the
// consumer; a newer pixel replaces an unaccepted one.
module afe_triplet_pack
  import afe_deint_pkg::*;
#(
  parameter int SAMP_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_i,
  input  logic                samp_vld_i,
  input  logic [SAMP_W-1:0]   samp_i,
  input  colour_e             tag_i,
  input  logic                ready_i,
  output logic                load_o,
  output logic                valid_o,
  output logic [3*SAMP_W-1:0] data_o
);
  logic [SAMP_W-1:0] red_q;
  logic [SAMP_W-1:0] grn_q;

  assign load_o = samp_vld_i && (tag_i == COL_BLU);

  always_ff @(posedge clk) begin
    if (rst) begin
      red_q   <= '0;
      grn_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (flush_i) begin
        red_q <= '0;
        grn_q <= '0;
      end else if (samp_vld_i) begin
        if (tag_i == COL_RED) red_q <= samp_i;
        if (tag_i == COL_GRN) grn_q <= samp_i;
      end
      if (load_o) begin
        data_o  <= {red_q, grn_q, samp_i};
        valid_o <= 1'b1;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/afe_rgb_deint.sv
module afe_rgb_deint
  import afe_deint_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SAMP_W      = 12,
  parameter int LAT_LONG    = 8,
  parameter int LAT_SHORT   = 6,
  parameter int SYNC_STAGES = 2,
  localparam int PIX_W      = 3 * SAMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adc_clk_i,
  input  logic             synch_i,
  input  logic             pack_mode_i,
  input  logic             lat_short_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             pix_ready_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_data_o
);
  logic              fall_d, rise_d, synch_s;
  colour_e           ptr, data_tag;
  logic              keep;
  logic [SAMP_W-1:0] samp;
  logic              samp_vld;
  logic              pix_load;

  afe_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .adc_clk_i(adc_clk_i), .synch_i(synch_i),
    .fall_o(fall_d), .rise_o(rise_d), .synch_o(synch_s)
  );

  afe_colour_track #(.LAT_LONG(LAT_LONG), .LAT_SHORT(LAT_SHORT)) u_track (
    .clk(clk), .rst(rst), .fall_i(fall_d), .synch_i(synch_s),
    .lat_short_i(lat_short_i), .ptr_o(ptr), .tag_o(data_tag), .keep_o(keep)
  );

  afe_word_unpack #(.BUS_W(BUS_W), .SAMP_W(SAMP_W)) u_unpack (
    .clk(clk), .rst(rst),
    .cap_hi_i(fall_d & ~synch_s), .cap_lo_i(rise_d & keep & ~synch_s),
    .pack_mode_i(pack_mode_i), .bus_i(bus_i),
    .samp_o(samp), .samp_vld_o(samp_vld)
  );

  afe_triplet_pack #(.SAMP_W(SAMP_W)) u_pack (
    .clk(clk), .rst(rst), .flush_i(synch_s),
    .samp_vld_i(samp_vld), .samp_i(samp), .tag_i(data_tag),
    .ready_i(pix_ready_i), .load_o(pix_load),
    .valid_o(pix_valid_o), .data_o(pix_data_o)
  );
endmodule

// File: rtl/afe_rgb_deint_chk.sv
module afe_rgb_deint_chk
  import afe_deint_pkg::*;
#(
  parameter int PIX_W     = 36,
  parameter int LAT_LONG  = 8,
  parameter int LAT_SHORT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             synch_s,
  input logic             fall_d,
  input logic             lat_short_i,
  input colour_e          ptr,
  input colour_e          data_tag,
  input logic             samp_vld,
  input logic             pix_load,
  input logic             pix_ready_i,
  input logic             pix_valid_o,
  input logic [PIX_W-1:0] pix_data_o
);
  logic [4:0] falls_seen;
  colour_e    last_tag;
  logic [4:0] need;

  assign need = lat_short_i ? 5'(LAT_SHORT + 1) : 5'(LAT_LONG + 1);

  always_ff @(posedge clk) begin
    if (rst || synch_s) begin
      falls_seen <= '0;
      last_tag   <= COL_BLU;
    end else begin
      if (fall_d && falls_seen != 5'd31) falls_seen <= falls_seen + 1'b1;
      if (samp_vld) last_tag <= data_tag;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !pix_valid_o); // R1

  AST_GRN_AFTER_RED: assert property (@(posedge clk) disable iff (rst)
    samp_vld && data_tag == COL_GRN |-> last_tag == COL_RED); // R4

  AST_BLU_AFTER_GRN: assert property (@(posedge clk) disable iff (rst)
    samp_vld && data_tag == COL_BLU |-> last_tag == COL_GRN); // R4

  AST_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    synch_s |=> ptr == COL_RED); // R5

  AST_QUIET_IN_SYNCH: assert property (@(posedge clk) disable iff (rst)
    synch_s && $past(synch_s) |=> !samp_vld); // R5

  AST_LATENCY_GATE: assert property (@(posedge clk) disable iff (rst)
    samp_vld |-> falls_seen >= need); // R6 R7

  AST_HOLD_PIXEL: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o && !pix_ready_i && !pix_load |=> pix_valid_o && $stable(pix_data_o)); // R8
endmodule

bind afe_rgb_deint afe_rgb_deint_chk #(
  .PIX_W(PIX_W), .LAT_LONG(LAT_LONG), .LAT_SHORT(LAT_SHORT)
) u_chk (
  .clk(clk), .rst(rst), .synch_s(synch_s), .fall_d(fall_d),
  .lat_short_i(lat_short_i), .ptr(ptr), .data_tag(data_tag),
  .samp_vld(samp_vld), .pix_load(pix_load), .pix_ready_i(pix_ready_i),
  .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o)
);

// File: tb/afe_rgb_deint_tb.sv
`timescale 1ns/1ps
module afe_rgb_deint_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adc_clk = 1'b1;
  logic        synch = 1'b1;
  logic        pack_mode = 1'b0;
  logic        lat_short = 1'b0;
  logic [7:0]  bus = 8'hFF;
  logic        ready = 1'b1;
  logic        pix_valid;
  logic [35:0] pix_data;

  int tests = 0;
  int fails = 0;
  logic [35:0] got [64];
  int got_n = 0;

  always #2 clk = ~clk;

  afe_rgb_deint u_dut (
    .clk(clk), .rst(rst), .adc_clk_i(adc_clk), .synch_i(synch),
    .pack_mode_i(pack_mode), .lat_short_i(lat_short), .bus_i(bus),
    .pix_ready_i(ready), .pix_valid_o(pix_valid), .pix_data_o(pix_data)
  );

  always @(negedge clk) begin
    if (!rst && pix_valid && ready) begin
      if (got_n < 64) got[got_n] = pix_data;
      got_n = got_n + 1;
    end
  end

  // {pack_mode, lat_short, nsamp[5:0], base[11:0], step[11:0]}
  localparam logic [31:0] VEC [5] = '{
    {1'b0, 1'b0, 6'd17, 12'h123, 12'h111},
    {1'b1, 1'b0, 6'd14, 12'hFA5, 12'h0C3},
    {1'b0, 1'b1, 6'd15, 12'h000, 12'hFFF},
    {1'b1, 1'b1, 6'd12, 12'hABC, 12'h357},
    {1'b1, 1'b0, 6'd10, 12'h800, 12'h001}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] sval(input logic [11:0] b, input logic [11:0] s, input int k);
    return 12'(b + 12'(k) * s);
  endfunction

  task automatic send_sample(input logic [11:0] v);
    adc_clk = 1'b0;
    bus = pack_mode ? v[11:4] : {v[11:6], 2'b11};
    wclk(5);
    adc_clk = 1'b1;
    bus = pack_mode ? {v[3:0], 4'hA} : {v[5:0], 2'b01};
    wclk(5);
  endtask

  task automatic idle(input int periods);
    synch = 1'b1;
    for (int i = 0; i < periods; i++) begin
      adc_clk = 1'b0; bus = 8'(8'h5A + i); wclk(5);
      adc_clk = 1'b1; bus = 8'hC3; wclk(5);
    end
  endtask

  task automatic release_sync();
    synch = 1'b0;
    wclk(5);
  endtask

  task automatic send_range(input logic [11:0] b, input logic [11:0] s, input int k0, input int k1);
    for (int k = k0; k < k1; k++) send_sample(sval(b, s, k));
  endtask

  function automatic logic [35:0] trip(input logic [11:0] b, input logic [11:0] s, input int k);
    return {sval(b, s, k), sval(b, s, k + 1), sval(b, s, k + 2)};
  endfunction

  task automatic finish_tb();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_tb();
  end

  initial begin
    int start;
    int lat;
    int n;
    wclk(4);
    rst = 1'b0;
    wclk(2);
    // R1 reset state
    chk("R1 valid", 64'(pix_valid), 64'd0);
    chk("R1 data", 64'(pix_data), 64'd0);

    // R5 bus activity while sync is high produces nothing
    start = got_n;
    idle(6);
    chk("R5 no pixel in sync", 64'(got_n - start), 64'd0);
    chk("R5 valid low in sync", 64'(pix_valid), 64'd0);

    // Table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < 5; v++) begin
      pack_mode = VEC[v][31];
      lat_short = VEC[v][30];
      n   = int'(VEC[v][29:24]);
      lat = lat_short ? 6 : 8;
      start = got_n;
      idle(2);
      release_sync();
      send_range(VEC[v][23:12], VEC[v][11:0], 0, n);
      idle(2);
      chk(lat_short ? "R7 pixel count" : "R6 pixel count",
          64'(got_n - start), 64'((n - lat) / 3));
      for (int j = 0; j < (n - lat) / 3; j++)
        chk(pack_mode ? "R3/R4 pixel" : "R2/R4 pixel", 64'(got[start + j]),
            64'(trip(VEC[v][23:12], VEC[v][11:0], lat + 3 * j)));
    end

    // R5 sync pulse in the middle of a triplet discards red and green
    pack_mode = 1'b0; lat_short = 1'b1;
    start = got_n;
    release_sync();
    send_range(12'h777, 12'h222, 0, 8);
    idle(2);
    release_sync();
    send_range(12'h0F0, 12'h10F, 0, 9);
    idle(2);
    chk("R5 partial discarded count", 64'(got_n - start), 64'd1);
    chk("R5 partial discarded data", 64'(got[start]), 64'(trip(12'h0F0, 12'h10F, 6)));

    // R8 hold under back-pressure, R9 replacement by newer triplet
    pack_mode = 1'b1; lat_short = 1'b1; ready = 1'b0;
    start = got_n;
    release_sync();
    send_range(12'h321, 12'h0AB, 0, 9);
    wclk(20);
    chk("R8 valid held", 64'(pix_valid), 64'd1);
    chk("R8 data held", 64'(pix_data), 64'(trip(12'h321, 12'h0AB, 6)));
    wclk(20);
    chk("R8 data stable", 64'(pix_data), 64'(trip(12'h321, 12'h0AB, 6)));
    send_range(12'h321, 12'h0AB, 9, 12);
    wclk(10);
    chk("R9 newer replaces", 64'(pix_data), 64'(trip(12'h321, 12'h0AB, 9)));
    synch = 1'b1;
    wclk(2);
    ready = 1'b1;
    wclk(10);
    chk("R9 single delivery", 64'(got_n - start), 64'd1);
    chk("R9 delivered word", 64'(got[start]), 64'(trip(12'h321, 12'h0AB, 9)));
    chk("R8 valid drops after accept", 64'(pix_valid), 64'd0);

    // R1 reset mid-stream clears output
    ready = 1'b0;
    release_sync();
    send_range(12'h456, 12'h001, 0, 9);
    wclk(10);
    rst = 1'b1; wclk(2); rst = 1'b0; wclk(1);
    chk("R1 valid after reset", 64'(pix_valid), 64'd0);
    chk("R1 data after reset", 64'(pix_data), 64'd0);

    finish_tb();
  end
endmodule